// File: doc/BRIEF.md
# Script Instruction Fetch Decoder

This block sits at the front of a script-driven DMA engine. It reads the instructions of a script program from memory through a word-wide read port and splits each one into its fields. It then offers the decoded instruction to an execution unit. Software starts a script by writing the start address into the script pointer while the block is idle. From then on the block walks the script by itself. It fetches one instruction, waits until the execution unit takes it, and then fetches the next instruction at the advanced pointer.

Every instruction is at least two 32-bit words long. The first word carries an 8-bit opcode in its top byte and a 24-bit byte count below it. The second word is an address operand, which for a block transfer is the memory start address. Only the memory-to-memory class, marked by the top two opcode bits, carries a third word, and the block loads that word into a separate extra-operand register. The pointer moves forward one word for each word fetched. When an instruction is presented, the pointer therefore already holds the address of the next instruction.

Top module: `script_fetch_decoder`

## Requirements
- R1: After a synchronous active-low reset, mem_req and ins_valid are 0 and script_ptr, ins_opcode, ins_count, ins_operand and ins_extra are all 0.
- R2: A host_ptr_we pulse while idle loads host_ptr_wdata into script_ptr. In the next cycle mem_req is 1 and mem_addr equals the written value.
- R3: Each word request goes to the address that follows the previous one by 4. Every acknowledged word adds 4 to script_ptr, so while ins_valid is 1, script_ptr is the start address plus 4 times the word count of the instruction.
- R4: Word 0 supplies ins_opcode from bits [31:24] and ins_count from bits [23:0].
- R5: Word 1 supplies ins_operand, all 32 bits.
- R6: When ins_opcode bits [7:6] are 2'b11, the block fetches a third word into ins_extra and sets ins_three_word to 1. Any other value gives a two-word instruction with ins_three_word 0 and ins_extra 0.
- R7: mem_req stays 1 with a constant mem_addr until mem_ack. A mem_ack while mem_req is 0 has no effect.
- R8: ins_valid stays 1 with constant instruction fields until ins_ready. No memory request is made while ins_valid is 1.
- R9: In the cycle after the handshake (ins_valid and ins_ready both 1), mem_req is 1 at address script_ptr, which fetches the next instruction.
- R10: A host_ptr_we pulse while a fetch is under way or an instruction is held has no effect on script_ptr or the fetch order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_ptr_we | input | 1 | Host write strobe for the script pointer |
| host_ptr_wdata | input | 32 | Script start address from the host |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read byte address |
| mem_ack | input | 1 | Read acknowledge; mem_rdata is valid with it |
| mem_rdata | input | 32 | Read data word |
| ins_valid | output | 1 | A decoded instruction is offered |
| ins_ready | input | 1 | The execution unit takes the instruction |
| ins_opcode | output | 8 | Opcode byte |
| ins_count | output | 24 | Byte count field |
| ins_operand | output | 32 | Second-word address operand |
| ins_extra | output | 32 | Third-word operand (0 for two-word instructions) |
| ins_three_word | output | 1 | Instruction came from three words |
| script_ptr | output | 32 | Current script pointer |

## Verification
On every cycle the assertions check the handshake rules: the request holds steady until it is acknowledged, each acknowledged word moves the pointer by 4, the held instruction stays fixed while it waits, no request is made while an instruction is held, and ins_three_word agrees with the opcode class. The bench scenarios cover what depends on memory contents and on the sequence of events. Field extraction and the address order are checked across every opcode class, under several memory latencies and consumer delays. The scenarios also check that host writes outside idle and stray acknowledges are ignored, that ins_extra stays 0 for two-word instructions, and the reset values.

// File: rtl/sfd_pkg.sv
// Package: shared state type and opcode-class helper for the script fetch decoder.
// Assumes the instruction class sits in the top two bits of the opcode.
package sfd_pkg;

    localparam int CLS_W = 2;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WORD0 = 3'd1,
        ST_WORD1 = 3'd2,
        ST_WORD2 = 3'd3,
        ST_HOLD  = 3'd4
    } fetch_state_t;

    // True when the class bits select the three-word (memory-move) class.
    function automatic logic is_mem_move(input logic [CLS_W-1:0] cls_bits,
                                         input logic [CLS_W-1:0] mm_code);
        return cls_bits == mm_code;
    endfunction

endpackage

// File: rtl/sfd_fsm.sv
// Fetch controller: steps through the instruction words, one request per word,
// and holds the result until the execution unit accepts it.
// Assumes mem_ack is honoured only while a request is raised.
module sfd_fsm
    import sfd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic host_ptr_we,
    input  logic mem_ack,
    input  logic ins_ready,
    input  logic three_word,
    output logic ptr_load,
    output logic ld_w0,
    output logic ld_w1,
    output logic ld_w2,
    output logic mem_req,
    output logic ins_valid
);

    fetch_state_t state_q, state_d;

    // Word-state outputs and load strobes.
    always_comb begin
        mem_req   = (state_q == ST_WORD0) || (state_q == ST_WORD1) || (state_q == ST_WORD2);
        ins_valid = (state_q == ST_HOLD);
        ptr_load  = (state_q == ST_IDLE) && host_ptr_we;
        ld_w0     = (state_q == ST_WORD0) && mem_ack;
        ld_w1     = (state_q == ST_WORD1) && mem_ack;
        ld_w2     = (state_q == ST_WORD2) && mem_ack;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (host_ptr_we) state_d = ST_WORD0;
            ST_WORD0: if (mem_ack)     state_d = ST_WORD1;
            ST_WORD1: if (mem_ack)     state_d = three_word ? ST_WORD2 : ST_HOLD;
            ST_WORD2: if (mem_ack)     state_d = ST_HOLD;
            ST_HOLD:  if (ins_ready)   state_d = ST_WORD0;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/sfd_ptr.sv
// Script pointer: loaded by the host, advanced one word per fetched word.
// Assumes load and step never occur in the same cycle (controller guarantees).
module sfd_ptr #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_load,
    input  logic              ptr_step,
    input  logic [ADDR_W-1:0] load_value,
    output logic [ADDR_W-1:0] ptr
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_W / 8);

    // Pointer register update.
    always_ff @(posedge clk) begin
        if (!rst_n)        ptr <= '0;
        else if (ptr_load) ptr <= load_value;
        else if (ptr_step) ptr <= ptr + STEP;
    end

endmodule

// File: rtl/sfd_regs.sv
// Instruction registers: splits word 0 into opcode and count, keeps word 1 as
// the operand and word 2 as the extra operand; reports the opcode class.
// Assumes the strobes come one per cycle in word order.
module sfd_regs
    import sfd_pkg::*;
#(
    parameter int              WORD_W   = 32,
    parameter int              OPC_W    = 8,
    parameter logic [CLS_W-1:0] MM_CLASS = 2'b11
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ld_w0,
    input  logic                    ld_w1,
    input  logic                    ld_w2,
    input  logic [WORD_W-1:0]       rdata,
    output logic [OPC_W-1:0]        opcode,
    output logic [WORD_W-OPC_W-1:0] count,
    output logic [WORD_W-1:0]       operand,
    output logic [WORD_W-1:0]       extra,
    output logic                    three_word
);

    localparam int CNT_W = WORD_W - OPC_W;

    // Command word split into opcode and byte count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opcode <= '0;
            count  <= '0;
        end else if (ld_w0) begin
            opcode <= rdata[WORD_W-1 -: OPC_W];
            count  <= rdata[CNT_W-1:0];
        end
    end

    // Address operand from the second word.
    always_ff @(posedge clk) begin
        if (!rst_n)     operand <= '0;
        else if (ld_w1) operand <= rdata;
    end

    // Extra operand: cleared at each new instruction, filled by a third word.
    always_ff @(posedge clk) begin
        if (!rst_n)     extra <= '0;
        else if (ld_w0) extra <= '0;
        else if (ld_w2) extra <= rdata;
    end

    // Class decode from the top opcode bits.
    always_comb three_word = is_mem_move(opcode[OPC_W-1 -: CLS_W], MM_CLASS);

endmodule

// File: rtl/script_fetch_decoder.sv
// Top: fetches two- or three-word script instructions from a word read port,
// decodes them and offers them on a valid/ready interface.
// Assumes one word per acknowledge and a host write only while idle matters.
module script_fetch_decoder #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int OPC_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    host_ptr_we,
    input  logic [ADDR_W-1:0]       host_ptr_wdata,
    output logic                    mem_req,
    output logic [ADDR_W-1:0]       mem_addr,
    input  logic                    mem_ack,
    input  logic [WORD_W-1:0]       mem_rdata,
    output logic                    ins_valid,
    input  logic                    ins_ready,
    output logic [OPC_W-1:0]        ins_opcode,
    output logic [WORD_W-OPC_W-1:0] ins_count,
    output logic [WORD_W-1:0]       ins_operand,
    output logic [WORD_W-1:0]       ins_extra,
    output logic                    ins_three_word,
    output logic [ADDR_W-1:0]       script_ptr
);

    logic ptr_load, ld_w0, ld_w1, ld_w2, ptr_step;

    // Any accepted word advances the pointer.
    always_comb ptr_step = ld_w0 | ld_w1 | ld_w2;

    // Requests always target the pointer.
    always_comb mem_addr = script_ptr;

    sfd_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_ptr_we(host_ptr_we),
        .mem_ack    (mem_ack),
        .ins_ready  (ins_ready),
        .three_word (ins_three_word),
        .ptr_load   (ptr_load),
        .ld_w0      (ld_w0),
        .ld_w1      (ld_w1),
        .ld_w2      (ld_w2),
        .mem_req    (mem_req),
        .ins_valid  (ins_valid)
    );

    sfd_ptr #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ptr_load  (ptr_load),
        .ptr_step  (ptr_step),
        .load_value(host_ptr_wdata),
        .ptr       (script_ptr)
    );

    sfd_regs #(.WORD_W(WORD_W), .OPC_W(OPC_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_w0     (ld_w0),
        .ld_w1     (ld_w1),
        .ld_w2     (ld_w2),
        .rdata     (mem_rdata),
        .opcode    (ins_opcode),
        .count     (ins_count),
        .operand   (ins_operand),
        .extra     (ins_extra),
        .three_word(ins_three_word)
    );

endmodule

// File: rtl/sfd_checker.sv
// Checker: handshake and pointer properties of the script fetch decoder,
// observed at its ports. Bound to every instance of the top module.
module sfd_checker #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int OPC_W  = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    mem_req,
    input logic [ADDR_W-1:0]       mem_addr,
    input logic                    mem_ack,
    input logic                    ins_valid,
    input logic                    ins_ready,
    input logic [OPC_W-1:0]        ins_opcode,
    input logic [WORD_W-OPC_W-1:0] ins_count,
    input logic [WORD_W-1:0]       ins_operand,
    input logic [WORD_W-1:0]       ins_extra,
    input logic                    ins_three_word,
    input logic [ADDR_W-1:0]       script_ptr
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_W / 8);

    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (script_ptr == $past(script_ptr) + STEP));

    p_ins_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !ins_ready) |=> (ins_valid && $stable(ins_opcode) && $stable(ins_count)
                                       && $stable(ins_operand) && $stable(ins_extra)));

    p_no_req_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |-> !mem_req);

    p_class_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |-> (ins_three_word == (ins_opcode[OPC_W-1 -: 2] == 2'b11)));

    p_extra_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !ins_three_word) |-> (ins_extra == '0));

    p_refetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_ready) |=> (mem_req && !ins_valid));

endmodule

bind script_fetch_decoder sfd_checker #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .OPC_W(OPC_W)) u_sfd_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_req       (mem_req),
    .mem_addr      (mem_addr),
    .mem_ack       (mem_ack),
    .ins_valid     (ins_valid),
    .ins_ready     (ins_ready),
    .ins_opcode    (ins_opcode),
    .ins_count     (ins_count),
    .ins_operand   (ins_operand),
    .ins_extra     (ins_extra),
    .ins_three_word(ins_three_word),
    .script_ptr    (script_ptr)
);

// File: tb/test_script_fetch_decoder.sv
// Bench: sweeps memory latency, consumer delay and program base over an
// eight-instruction script with every opcode class; expected fields computed here.
module test_script_fetch_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_ptr_we = 1'b0;
    logic [31:0] host_ptr_wdata = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        ins_valid;
    logic        ins_ready = 1'b0;
    logic [7:0]  ins_opcode;
    logic [23:0] ins_count;
    logic [31:0] ins_operand;
    logic [31:0] ins_extra;
    logic        ins_three_word;
    logic [31:0] script_ptr;

    always #5 clk = ~clk;

    script_fetch_decoder i_script_fetch_decoder (
        .clk(clk), .rst_n(rst_n), .host_ptr_we(host_ptr_we), .host_ptr_wdata(host_ptr_wdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_opcode(ins_opcode),
        .ins_count(ins_count), .ins_operand(ins_operand), .ins_extra(ins_extra),
        .ins_three_word(ins_three_word), .script_ptr(script_ptr)
    );

    localparam int NINS = 8;

    logic [31:0] mem [0:63];
    logic [7:0]  e_opc [0:NINS-1];
    logic [23:0] e_cnt [0:NINS-1];
    logic [31:0] e_opr [0:NINS-1];
    logic [31:0] e_ext [0:NINS-1];
    logic [31:0] e_beg [0:NINS-1];
    logic        e_three [0:NINS-1];

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int lat = 0;
    int wait_cnt = 0;
    bit stray = 1'b0;
    logic [31:0] exp_addr = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Memory model: acknowledges after lat idle cycles, checks address order (R3, R7).
    always @(negedge clk) begin
        if (rst_n && mem_req) begin
            if (wait_cnt >= lat) begin
                check(mem_addr == exp_addr, "R3", "request address", mem_addr, exp_addr);
                mem_ack   = 1'b1;
                mem_rdata = mem[mem_addr[7:2]];
                exp_addr  = exp_addr + 32'd4;
                wait_cnt  = 0;
            end else begin
                mem_ack  = 1'b0;
                wait_cnt = wait_cnt + 1;
            end
        end else begin
            wait_cnt  = 0;
            mem_ack   = stray;
            mem_rdata = 32'hDEAD_BEEF;
        end
    end

    // Builds the program at word index wbase for scenario s.
    task automatic build(input int s, input int wbase);
        int wi;
        wi = wbase;
        for (int i = 0; i < 64; i++) mem[i] = 32'h5A5A_0000 + 32'(i);
        for (int k = 0; k < NINS; k++) begin
            logic [1:0] cls;
            cls = 2'((k + s) % 4);
            e_opc[k] = {cls, 6'(k * 5 + s)};
            e_cnt[k] = 24'(k * 4099 + s * 7 + 1);
            if (k == NINS - 1) begin
                e_opc[k] = 8'hFF;
                e_cnt[k] = 24'hFF_FFFF;
            end
            e_three[k] = (e_opc[k][7:6] == 2'b11);
            e_opr[k] = 32'h4000_0000 + 32'(k * 256 + s);
            e_ext[k] = e_three[k] ? (32'hC000_0000 ^ 32'(k << 8) ^ 32'(s)) : 32'h0;
            e_beg[k] = 32'(wi * 4);
            mem[wi] = {e_opc[k], e_cnt[k]};
            mem[wi + 1] = e_opr[k];
            if (e_three[k]) mem[wi + 2] = e_ext[k];
            wi = wi + (e_three[k] ? 3 : 2);
        end
    endtask

    initial begin
        for (int s = 0; s < 9; s++) begin
            int rdly;
            logic [31:0] base;
            lat   = s / 3;
            rdly  = s % 3;
            stray = (s % 2 == 1);
            base  = 32'((s % 4) * 16);
            build(s, int'(base >> 2));

            rst_n = 1'b0;
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            // R1: reset state
            check(!mem_req && !ins_valid, "R1", "req/valid after reset", {30'b0, mem_req, ins_valid}, 32'h0);
            check(script_ptr == 0 && ins_opcode == 0 && ins_count == 0 && ins_operand == 0 && ins_extra == 0,
                  "R1", "registers after reset", script_ptr | {8'h0, ins_count} | ins_operand | ins_extra, 32'h0);

            // R2: start the script
            exp_addr = base;
            host_ptr_we = 1'b1;
            host_ptr_wdata = base;
            @(negedge clk);
            host_ptr_we = 1'b0;
            check(mem_req && mem_addr == base, "R2", "first request address", mem_addr, base);

            for (int k = 0; k < NINS; k++) begin
                logic [31:0] nxt;
                nxt = e_beg[k] + (e_three[k] ? 32'd12 : 32'd8);
                while (!ins_valid) @(negedge clk);
                check(ins_opcode == e_opc[k], "R4", "opcode", {24'h0, ins_opcode}, {24'h0, e_opc[k]});
                check(ins_count == e_cnt[k], "R4", "count", {8'h0, ins_count}, {8'h0, e_cnt[k]});
                check(ins_operand == e_opr[k], "R5", "operand", ins_operand, e_opr[k]);
                check(ins_extra == e_ext[k] && ins_three_word == e_three[k], "R6", "extra operand",
                      ins_extra, e_ext[k]);
                check(script_ptr == nxt, "R3", "pointer at decode", script_ptr, nxt);
                for (int d = 0; d < rdly; d++) begin
                    @(negedge clk);
                    check(ins_valid && !mem_req && ins_operand == e_opr[k], "R8", "held instruction",
                          ins_operand, e_opr[k]);
                end
                if (k == 3) begin
                    // R10: host write while an instruction is held
                    host_ptr_we = 1'b1;
                    host_ptr_wdata = 32'h0000_0F00;
                    @(negedge clk);
                    host_ptr_we = 1'b0;
                    check(script_ptr == nxt && ins_valid, "R10", "pointer after write in hold", script_ptr, nxt);
                end
                ins_ready = 1'b1;
                @(negedge clk);
                ins_ready = 1'b0;
                // R9: next fetch starts right after the handshake
                check(mem_req && !ins_valid && mem_addr == nxt, "R9", "refetch address", mem_addr, nxt);
                if (k == 1) begin
                    // R10: host write during a fetch (order checked by the memory model)
                    host_ptr_we = 1'b1;
                    host_ptr_wdata = 32'h0000_0F00;
                    @(negedge clk);
                    host_ptr_we = 1'b0;
                end
            end
        end
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule